// File: doc/BRIEF.md
# Central Sharer-Vector Directory Controller

This block is the home-memory controller of a small shared-memory multiprocessor. A fixed set of direct-mapped caches talk to it through one request packet port. For every memory line it holds the data block and a sharer vector with one bit per cache. Each request is a read miss, a write from a cache that hit, a write from a cache that missed, or an eviction notice. For each request the controller updates the block and the sharer vector, and then sends its reply packets through one valid/ready output port.

When one cache writes, the other caches that share the line are told about it. A static parameter picks how. In update mode each other sharer gets the new data and stays in the vector. In invalidate mode each other sharer gets an invalidate message and is removed, so only the writer's bit stays set. Before a cache refills a line that holds a different valid address, it sends an eviction notice. The controller clears that cache's bit and acknowledges. The cache issues its refill read or write only after that acknowledgement arrives.

The controller works on one request at a time. It keeps its input not-ready until the last reply packet for the current request has left. Packet op codes: inputs use 1 = read miss, 2 = write hit, 3 = write miss, 4 = evict. Outputs use 1 = data, 2 = write ack, 3 = evict ack, 4 = update, 5 = invalidate.

Top module: `dirctl_home`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. Every line holds data 0 and has an empty sharer vector.
- R2: A read miss (in op 1) sets the requester's sharer bit. It produces exactly one data packet (out op 1) to the requester, carrying the line's current block.
- R3: In update mode, a write hit (in op 2) stores the data and sends an update packet (out op 4, carrying the new data) to every other sharer. It then sends a write ack (out op 2, carrying the stored block) to the requester, and the requester's bit ends up set.
- R4: A write miss (in op 3) behaves like a write hit: the other sharers are told according to the policy, the requester joins the sharer set, and the write ack returns the updated block.
- R5: An evict request (in op 4) clears only the requester's bit. It produces exactly one evict-ack packet (out op 3, data 0) and no other packet. Later writes send nothing to the evicted cache.
- R6: Sharer messages for a write go out one per accepted handshake, in ascending cache-index order, and never to the requester. All of them come before the requester's reply.
- R7: In invalidate mode a write sends invalidate packets (out op 5, data 0) to the other sharers, and afterwards only the writer's bit is set. No update packets are ever sent in this mode.
- R8: `in_ready` is 0 from the cycle after a request is accepted until the last reply handshake, and is 1 again in the following cycle. A request is never accepted while an output packet is pending.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value.
- R10: A request with any other op code (0, 5, 6, 7) is consumed without producing a reply. It changes neither the data nor the sharer vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request packet present |
| in_ready | output | 1 | Controller idle and able to take a request |
| in_op | input | 3 | Request op code |
| in_src | input | CID_W | Index of the requesting cache |
| in_addr | input | ADDR_W | Line index |
| in_data | input | DATA_W | Write data |
| out_valid | output | 1 | Output packet present |
| out_ready | input | 1 | Network can take the output packet |
| out_op | output | 3 | Output op code |
| out_dest | output | CID_W | Destination cache |
| out_addr | output | ADDR_W | Line index |
| out_data | output | DATA_W | Block data or 0 |

## Verification
The bench sweeps every sharer set of a four-cache system against every writer, under both policies. It covers the writer being in the set or outside it, and the set being empty or full. If a design skipped the self-exclusion, the writer would receive its own update. If it walked the vector in the wrong order, packets would arrive out of sequence. If it failed to shrink the vector in invalidate mode, a later write would still reach caches that were dropped. The bench drops `out_ready` on a fixed pattern, so a design that let `in_ready` rise early would take a request in the middle of a reply, and a design that advanced on a stalled handshake would lose a packet. Unsupported op codes are followed by a read of the same line, so a design that decoded them as writes would return corrupted data.

// File: rtl/dirctl_pkg.sv
package dirctl_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        PKT_NONE = 3'd0,
        PKT_DATA = 3'd1,
        PKT_WACK = 3'd2,
        PKT_IACK = 3'd3,
        PKT_UPD  = 3'd4,
        PKT_INV  = 3'd5
    } pkt_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FAN   = 2'd1,
        ST_REPLY = 2'd2
    } state_e;

    typedef struct packed {
        logic    valid;
        logic    is_read;
        logic    is_write;
        logic    is_evict;
        pkt_op_e reply;
    } req_ctl_t;

    function automatic req_ctl_t decode_req(logic [OP_W-1:0] op);
        req_ctl_t c;
        c = '{valid: 1'b0, is_read: 1'b0, is_write: 1'b0, is_evict: 1'b0, reply: PKT_NONE};
        case (op)
            3'd1: begin c.valid = 1'b1; c.is_read  = 1'b1; c.reply = PKT_DATA; end
            3'd2,
            3'd3: begin c.valid = 1'b1; c.is_write = 1'b1; c.reply = PKT_WACK; end
            3'd4: begin c.valid = 1'b1; c.is_evict = 1'b1; c.reply = PKT_IACK; end
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic is_fan_op(logic [OP_W-1:0] op);
        return (op == PKT_UPD) || (op == PKT_INV);
    endfunction

endpackage

// File: rtl/dirctl_store.sv
module dirctl_store #(
    parameter int N_CACHES = 4,
    parameter int N_LINES  = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [N_CACHES-1:0] rd_dir,
    input  logic                we,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                wr_data_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [N_CACHES-1:0] wr_dir
);
    logic [DATA_W-1:0]   blk_q [N_LINES];
    logic [N_CACHES-1:0] vec_q [N_LINES];

    assign rd_data = blk_q[rd_addr];
    assign rd_dir  = vec_q[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_LINES; i++) begin
                blk_q[i] <= '0;
                vec_q[i] <= '0;
            end
        end else if (we) begin
            vec_q[wr_addr] <= wr_dir;
            if (wr_data_en) begin
                blk_q[wr_addr] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/dirctl_lowbit.sv
module dirctl_lowbit #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     mask,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = IDX_W'(i);
            end
        end
        any    = |mask;
        onehot = any ? (N'(1) << idx) : '0;
        // R6
        if (any) begin
            pick_lowest_chk: assert (((onehot & mask) == onehot) && ((mask & (onehot - N'(1))) == '0));
        end
    end
endmodule

// File: rtl/dirctl_pktout.sv
module dirctl_pktout
    import dirctl_pkg::*;
#(
    parameter int CID_W  = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  state_e              state,
    input  logic [CID_W-1:0]    fan_idx,
    input  pkt_op_e             fan_op,
    input  logic [DATA_W-1:0]   fan_data,
    input  pkt_op_e             reply_op,
    input  logic [CID_W-1:0]    reply_dest,
    input  logic [DATA_W-1:0]   reply_data,
    input  logic [ADDR_W-1:0]   line_addr,
    output logic                out_valid,
    output logic [OP_W-1:0]     out_op,
    output logic [CID_W-1:0]    out_dest,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [DATA_W-1:0]   out_data
);
    always_comb begin
        out_valid = 1'b0;
        out_op    = PKT_NONE;
        out_dest  = '0;
        out_data  = '0;
        out_addr  = line_addr;
        case (state)
            ST_FAN: begin
                out_valid = 1'b1;
                out_op    = fan_op;
                out_dest  = fan_idx;
                out_data  = fan_data;
            end
            ST_REPLY: begin
                out_valid = 1'b1;
                out_op    = reply_op;
                out_dest  = reply_dest;
                out_data  = reply_data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dirctl_home.sv
module dirctl_home
    import dirctl_pkg::*;
#(
    parameter int N_CACHES        = 4,
    parameter int N_LINES         = 16,
    parameter int DATA_W          = 32,
    parameter bit WRITE_INVALIDATE = 1'b0,
    localparam int CID_W  = (N_CACHES > 1) ? $clog2(N_CACHES) : 1,
    localparam int ADDR_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_op,
    input  logic [CID_W-1:0]  in_src,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_op,
    output logic [CID_W-1:0]  out_dest,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    state_e              state_q;
    logic [CID_W-1:0]    src_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    pkt_op_e             reply_q;
    logic [N_CACHES-1:0] fan_q;

    req_ctl_t            ctl;
    logic                accept;
    logic [N_CACHES-1:0] src_bit;
    logic [DATA_W-1:0]   rd_data;
    logic [N_CACHES-1:0] rd_dir;
    logic [N_CACHES-1:0] write_dir;
    logic [N_CACHES-1:0] wr_dir;
    logic [N_CACHES-1:0] fan_seed;
    logic [N_CACHES-1:0] fan_rest;
    logic                fan_any;
    logic [CID_W-1:0]    fan_idx;
    logic [N_CACHES-1:0] fan_onehot;
    pkt_op_e             fan_op;
    logic [DATA_W-1:0]   fan_data;

    assign ctl      = decode_req(in_op);
    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign src_bit  = N_CACHES'(1) << in_src;
    assign fan_seed = ctl.is_write ? (rd_dir & ~src_bit) : '0;
    assign fan_rest = fan_q & ~fan_onehot;

    generate
        if (WRITE_INVALIDATE) begin : g_inv
            assign write_dir = src_bit;
            assign fan_op    = PKT_INV;
            assign fan_data  = '0;
        end else begin : g_upd
            assign write_dir = rd_dir | src_bit;
            assign fan_op    = PKT_UPD;
            assign fan_data  = data_q;
        end
    endgenerate

    always_comb begin
        wr_dir = rd_dir;
        if (ctl.is_read) begin
            wr_dir = rd_dir | src_bit;
        end else if (ctl.is_evict) begin
            wr_dir = rd_dir & ~src_bit;
        end else if (ctl.is_write) begin
            wr_dir = write_dir;
        end
    end

    dirctl_store #(
        .N_CACHES(N_CACHES), .N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) i_store (
        .clk       (clk),
        .rst       (rst),
        .rd_addr   (in_addr),
        .rd_data   (rd_data),
        .rd_dir    (rd_dir),
        .we        (accept && ctl.valid),
        .wr_addr   (in_addr),
        .wr_data_en(ctl.is_write),
        .wr_data   (in_data),
        .wr_dir    (wr_dir)
    );

    dirctl_lowbit #(.N(N_CACHES), .IDX_W(CID_W)) i_lowbit (
        .mask  (fan_q),
        .any   (fan_any),
        .idx   (fan_idx),
        .onehot(fan_onehot)
    );

    dirctl_pktout #(.CID_W(CID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pktout (
        .state     (state_q),
        .fan_idx   (fan_idx),
        .fan_op    (fan_op),
        .fan_data  (fan_data),
        .reply_op  (reply_q),
        .reply_dest(src_q),
        .reply_data(data_q),
        .line_addr (addr_q),
        .out_valid (out_valid),
        .out_op    (out_op),
        .out_dest  (out_dest),
        .out_addr  (out_addr),
        .out_data  (out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            src_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            reply_q <= PKT_NONE;
            fan_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept && ctl.valid) begin
                        src_q   <= in_src;
                        addr_q  <= in_addr;
                        data_q  <= ctl.is_write ? in_data : (ctl.is_read ? rd_data : '0);
                        reply_q <= ctl.reply;
                        fan_q   <= fan_seed;
                        state_q <= (|fan_seed) ? ST_FAN : ST_REPLY;
                    end
                end
                ST_FAN: begin
                    if (out_ready && fan_any) begin
                        fan_q <= fan_rest;
                        if (fan_rest == '0) begin
                            state_q <= ST_REPLY;
                        end
                    end
                end
                ST_REPLY: begin
                    if (out_ready) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    no_accept_while_sending_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> !out_valid);

    // R9
    hold_when_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_dest)
                                        && $stable(out_addr) && $stable(out_data)));

    // R6
    fan_ascending_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && is_fan_op(out_op)) |=>
            (!(out_valid && is_fan_op(out_op)) || (out_dest > $past(out_dest))));

    // R6
    fan_not_self_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && is_fan_op(out_op)) |-> (out_dest != src_q));

    // R8
    idle_after_reply_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !is_fan_op(out_op)) |=> (in_ready && !out_valid));

    generate
        if (WRITE_INVALIDATE) begin : g_inv_chk
            // R7
            no_update_in_inv_chk: assert property (@(posedge clk) disable iff (rst)
                !(out_valid && out_op == 3'(PKT_UPD)));
        end else begin : g_upd_chk
            // R3
            no_invalidate_in_upd_chk: assert property (@(posedge clk) disable iff (rst)
                !(out_valid && out_op == 3'(PKT_INV)));
        end
    endgenerate
endmodule

// File: tb/test_dirctl_home.sv
module test_dirctl_home;
    localparam int NC = 4;
    localparam int NL = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [2:0]    in_op   = '0;
    logic [1:0]    in_src  = '0;
    logic [2:0]    in_addr = '0;
    logic [DW-1:0] in_data = '0;

    logic          in_valid_v  [2];
    logic          in_ready_v  [2];
    logic          out_valid_v [2];
    logic          out_ready_v [2];
    logic [2:0]    out_op_v    [2];
    logic [1:0]    out_dest_v  [2];
    logic [2:0]    out_addr_v  [2];
    logic [DW-1:0] out_data_v  [2];

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [NC-1:0] mdir [2][NL];
    logic [DW-1:0] mmem [2][NL];

    logic [23:0] exp_pkt [16];
    string       exp_tag [16];
    int          n_exp;

    dirctl_home #(.N_CACHES(NC), .N_LINES(NL), .DATA_W(DW), .WRITE_INVALIDATE(1'b0)) i_dirctl_home (
        .clk(clk), .rst(rst),
        .in_valid(in_valid_v[0]), .in_ready(in_ready_v[0]),
        .in_op(in_op), .in_src(in_src), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid_v[0]), .out_ready(out_ready_v[0]),
        .out_op(out_op_v[0]), .out_dest(out_dest_v[0]), .out_addr(out_addr_v[0]), .out_data(out_data_v[0])
    );

    dirctl_home #(.N_CACHES(NC), .N_LINES(NL), .DATA_W(DW), .WRITE_INVALIDATE(1'b1)) i_dirctl_home_inv (
        .clk(clk), .rst(rst),
        .in_valid(in_valid_v[1]), .in_ready(in_ready_v[1]),
        .in_op(in_op), .in_src(in_src), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid_v[1]), .out_ready(out_ready_v[1]),
        .out_op(out_op_v[1]), .out_dest(out_dest_v[1]), .out_addr(out_addr_v[1]), .out_data(out_data_v[1])
    );

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic push(logic [2:0] op, int dest, int addr, logic [DW-1:0] data, string tag);
        exp_pkt[n_exp] = {op, 2'(dest), 3'(addr), data};
        exp_tag[n_exp] = tag;
        n_exp++;
    endtask

    task automatic run_req(int d, logic [2:0] op, int src, int addr, logic [DW-1:0] data, string pre);
        logic [NC-1:0] b;
        logic [NC-1:0] old;
        logic [23:0]   got;
        logic [23:0]   held;
        bit            stalled;
        int            k;
        int            cyc;
        b   = NC'(1) << src;
        old = mdir[d][addr];
        n_exp = 0;
        case (op)
            3'd1: begin
                mdir[d][addr] = old | b;
                push(3'd1, src, addr, mmem[d][addr], {pre, " R2 read reply"});
            end
            3'd2, 3'd3: begin
                mmem[d][addr] = data;
                for (int i = 0; i < NC; i++) begin
                    if (old[i] && i != src) begin
                        if (d == 1) push(3'd5, i, addr, '0, {pre, " R6 R7 invalidate"});
                        else        push(3'd4, i, addr, data, {pre, " R6 R3 update"});
                    end
                end
                mdir[d][addr] = (d == 1) ? b : (old | b);
                push(3'd2, src, addr, data, (op == 3'd2) ? {pre, " R3 write ack"} : {pre, " R4 write ack"});
            end
            3'd4: begin
                mdir[d][addr] = old & ~b;
                push(3'd3, src, addr, '0, {pre, " R5 evict ack"});
            end
            default: ;
        endcase

        @(negedge clk);
        in_op   = op;
        in_src  = 2'(src);
        in_addr = 3'(addr);
        in_data = data;
        in_valid_v[d] = 1'b1;
        cyc = 0;
        while (!in_ready_v[d] && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
        in_valid_v[d] = 1'b0;

        k = 0;
        cyc = 0;
        stalled = 1'b0;
        held = '0;
        while (k < n_exp && cyc < 60) begin
            out_ready_v[d] = ((cyc % 4) != 2);
            #1;
            got = {out_op_v[d], out_dest_v[d], out_addr_v[d], out_data_v[d]};
            check(!in_ready_v[d], {pre, " R8 ready low while busy"}, 32'(in_ready_v[d]), 32'd0);
            if (stalled) begin
                check(out_valid_v[d] && got == held, {pre, " R9 stalled packet held"}, 32'(got), 32'(held));
            end
            stalled = out_valid_v[d] && !out_ready_v[d];
            held    = got;
            if (out_valid_v[d] && out_ready_v[d]) begin
                check(got == exp_pkt[k], exp_tag[k], 32'(got), 32'(exp_pkt[k]));
                k++;
            end
            @(negedge clk);
            cyc++;
        end
        if (k < n_exp) begin
            check(1'b0, {pre, " R8 reply timeout"}, 32'(k), 32'(n_exp));
        end
        out_ready_v[d] = 1'b0;
        #1;
        check(in_ready_v[d] && !out_valid_v[d], {pre, " R8 idle after last reply"},
              32'({in_ready_v[d], out_valid_v[d]}), 32'b10);
        if (n_exp == 0) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                #1;
                check(!out_valid_v[d] && in_ready_v[d], {pre, " R10 no reply to unknown op"},
                      32'(out_valid_v[d]), 32'd0);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            in_valid_v[d]  = 1'b0;
            out_ready_v[d] = 1'b0;
            for (int a = 0; a < NL; a++) begin
                mdir[d][a] = '0;
                mmem[d][a] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        for (int d = 0; d < 2; d++) begin
            check(in_ready_v[d] && !out_valid_v[d], "R1 reset handshake state",
                  32'({in_ready_v[d], out_valid_v[d]}), 32'b10);
        end
        // R1: every line starts empty with zero data; a write shows no sharers
        for (int d = 0; d < 2; d++) begin
            for (int a = 0; a < NL; a++) begin
                run_req(d, 3'd3, 1, a, 16'(a + 16'h0100), "R1 fresh line");
                run_req(d, 3'd4, 1, a, '0, "R1");
                run_req(d, 3'd1, 0, a, '0, "R1");
                run_req(d, 3'd4, 0, a, '0, "R1");
            end
        end

        // Sweep every sharer set against every writer, both policies
        for (int d = 0; d < 2; d++) begin
            for (int m = 0; m < 16; m++) begin
                for (int w = 0; w < NC; w++) begin
                    int a;
                    a = (m * NC + w) % NL;
                    for (int c = 0; c < NC; c++) run_req(d, 3'd4, c, a, '0, "sweep");
                    for (int c = 0; c < NC; c++) begin
                        if (m[c]) run_req(d, 3'd1, c, a, '0, "sweep");
                    end
                    run_req(d, m[w] ? 3'd2 : 3'd3, w, a, 16'(16'h1000 + d * 16'h0800 + m * 16 + w), "sweep");
                    run_req(d, 3'd1, (w + 1) % NC, a, '0, "sweep");
                    run_req(d, 3'd3, (w + 2) % NC, a, 16'(16'h2000 + m * 16 + w), "sweep");
                end
            end
        end

        // R10: unsupported op codes leave block and sharers untouched
        for (int d = 0; d < 2; d++) begin
            run_req(d, 3'd0, 2, 5, 16'hDEAD, "R10");
            run_req(d, 3'd7, 3, 5, 16'hBEEF, "R10");
            run_req(d, 3'd6, 1, 5, 16'hCAFE, "R10");
            run_req(d, 3'd1, 0, 5, '0, "R10 data kept");
            run_req(d, 3'd3, 1, 5, 16'h0055, "R10 sharers kept");
        end

        finish_run();
    end
endmodule